// File: doc/BRIEF.md
# Disk Device Control and Data Port Register Logic

This block sits on the device side of a parallel disk register interface. It holds the host-writable device control register and the 16-bit data port. Through the control register the host selects the high-order byte of the extended address registers, holds the device in software reset and masks the host interrupt. Writing any command-block register drops the high-order-byte select again. The block drives an internal reset for the rest of the device and a host interrupt line. That line is gated by the interrupt mask and by whether this device is the one currently selected.

The data port moves words between a device-side buffer and the host. The device opens a block of a given length, in full-word or check-byte mode. While the block is open, the data-request flag (DRQ) is high, and each host data access pops or pushes one buffer word. Accesses made while DRQ is low have no effect on the buffer. The software reset has a minimum hold time, given in clock cycles by a parameter. A release that comes too early is delayed until that time has passed.

Reset sequencer states: RS_RUN (normal operation), RS_HOLD (reset requested, hold time running), RS_ARMED (hold time met, reset still requested) and RS_EXTEND (request withdrawn before the hold time was met). Transitions: RUN→HOLD when the reset bit is set. HOLD→ARMED when the time is met with the bit still set. HOLD→RUN when the time is met with the bit clear. HOLD→EXTEND when the bit clears early. EXTEND→HOLD when the bit is set again. EXTEND→RUN or EXTEND→ARMED when the time is met. ARMED→RUN when the bit clears. Data port states: DS_IDLE and DS_XFER. Transitions: IDLE→XFER on a block start of nonzero length outside reset. XFER→IDLE on the final counted access, or at once on internal reset.

Top module: `ata_devctl_port`

## Requirements
- R1: A read of address 8 returns the control image: bit 7 high-order-byte select, bit 3 always 1, bit 2 reset request, bit 1 interrupt mask, all other bits 0. After power-on reset it reads 0x0008. A write to address 8 loads bits 7, 2 and 1 of the write data.
- R2: A host write to any address 0 to 7 clears the high-order-byte select in the cycle after the write.
- R3: Setting the reset bit raises dev_reset in the cycle after the write. One cycle later, DRQ, the word count and any pending interrupt are cleared.
- R4: dev_reset stays high while the reset bit is 1. It falls only after the reset has been held for more than MIN_HOLD cycles. If the bit is cleared early, dev_reset stays high until that time has passed.
- R5: host_intrq is high only when an interrupt is pending, the mask bit is 0 and this device is selected. The device is selected when bit 4 of the last write to address 6 equals dev_strap.
- R6: A pulse on irq_req outside reset latches a pending interrupt. It stays latched while masked or deselected and appears as soon as both gates open. A host read of address 7 clears it.
- R7: While DRQ is 1, a data read (address 0) returns buf_rd_data and pulses buf_pop, and a data write pulses buf_push with the write data. In check-byte mode only bits 7:0 are carried and bits 15:8 are 0.
- R8: While DRQ is 0, a data read returns 0 and pulses neither buf_pop nor buf_push, and a data write pushes nothing.
- R9: xfer_start with a nonzero xfer_len outside reset raises DRQ in the next cycle. DRQ falls after exactly xfer_len data accesses. A start during reset is ignored.
- R10: A read of address 7 returns the status: bit 7 is dev_reset, bit 3 is DRQ, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| dev_strap | input | 1 | Device number of this unit, 0 or 1 |
| host_addr | input | 4 | Register address: 0 data, 0 to 7 command block, 6 device select, 7 status/command, 8 control |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the cycle of host_rd |
| host_intrq | output | 1 | Gated host interrupt |
| irq_req | input | 1 | Device-internal interrupt request pulse |
| xfer_start | input | 1 | Opens a data block |
| xfer_len | input | 8 | Block length in accesses |
| xfer_ecc | input | 1 | Block uses check-byte (8-bit) mode |
| buf_rd_data | input | 16 | Word offered by the device buffer |
| buf_pop | output | 1 | Buffer word consumed by a host read |
| buf_wr_data | output | 16 | Word written into the device buffer |
| buf_push | output | 1 | Buffer write strobe |
| drq | output | 1 | Data request flag |
| dev_reset | output | 1 | Internal device reset |
| hob | output | 1 | High-order-byte select |

## Verification
The assertions assume that host_rd and host_wr are never high in the same cycle and that each strobe lasts exactly one clock. They also assume that irq_req and xfer_start are single-cycle pulses. The bench drives every access through one task that raises a single strobe on a falling edge and drops it after the next rising edge, so these conditions always hold. It gives xfer_start a nonzero length outside reset, except in the one case that tests a start during reset.

// File: rtl/ata_devctl_pkg.sv
package ata_devctl_pkg;

    typedef enum logic [1:0] {
        RS_RUN,
        RS_HOLD,
        RS_ARMED,
        RS_EXTEND
    } rst_state_t;

    typedef enum logic {
        DS_IDLE,
        DS_XFER
    } dp_state_t;

    localparam int unsigned REG_DATA       = 0;
    localparam int unsigned REG_DEVSEL     = 6;
    localparam int unsigned REG_CMDSTAT    = 7;
    localparam int unsigned REG_DEVCTL     = 8;
    localparam int unsigned CMD_BLOCK_LAST = 7;

    localparam int unsigned CTL_HOB  = 7;
    localparam int unsigned CTL_ONE  = 3;
    localparam int unsigned CTL_SRST = 2;
    localparam int unsigned CTL_NIEN = 1;
    localparam int unsigned SEL_DEV  = 4;

    localparam int unsigned STAT_BUSY = 7;
    localparam int unsigned STAT_DRQ  = 3;

endpackage

// File: rtl/devctl_regs.sv
module devctl_regs
    import ata_devctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit_hob,
    input  logic              wbit_srst,
    input  logic              wbit_nien,
    input  logic              wbit_dev,
    output logic              hob,
    output logic              srst,
    output logic              nien,
    output logic              dev_sel
);

    logic cmd_wr;
    logic ctl_wr;
    logic sel_wr;

    always_comb begin
        cmd_wr = wr && (addr <= ADDR_W'(CMD_BLOCK_LAST));
        ctl_wr = wr && (addr == ADDR_W'(REG_DEVCTL));
        sel_wr = wr && (addr == ADDR_W'(REG_DEVSEL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hob     <= 1'b0;
            srst    <= 1'b0;
            nien    <= 1'b0;
            dev_sel <= 1'b0;
        end else begin
            if (ctl_wr) begin
                hob  <= wbit_hob;
                srst <= wbit_srst;
                nien <= wbit_nien;
            end else if (cmd_wr) begin
                hob <= 1'b0;
            end
            if (sel_wr) begin
                dev_sel <= wbit_dev;
            end
        end
    end

    AST_HOB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !hob); // R2

endmodule

// File: rtl/devctl_rst_seq.sv
module devctl_rst_seq
    import ata_devctl_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    output logic dev_reset
);

    localparam int CNT_W = $clog2(MIN_HOLD + 1);

    rst_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_done;

    assign cnt_done = (cnt_q == CNT_W'(MIN_HOLD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == RS_RUN) begin
            cnt_q <= '0;
        end else if (!cnt_done && (state_q != RS_ARMED)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN: begin
                if (srst) state_d = RS_HOLD;
            end
            RS_HOLD: begin
                if (cnt_done) state_d = srst ? RS_ARMED : RS_RUN;
                else if (!srst) state_d = RS_EXTEND;
            end
            RS_ARMED: begin
                if (!srst) state_d = RS_RUN;
            end
            RS_EXTEND: begin
                if (cnt_done) state_d = srst ? RS_ARMED : RS_RUN;
                else if (srst) state_d = RS_HOLD;
            end
        endcase
    end

    always_comb begin
        dev_reset = srst || (state_q != RS_RUN);
    end

    logic [CNT_W:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!dev_reset) begin
            held_q <= '0;
        end else if (int'(held_q) < MIN_HOLD) begin
            held_q <= held_q + (CNT_W+1)'(1);
        end
    end

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_reset) |-> (int'($past(held_q)) >= MIN_HOLD)); // R4

endmodule

// File: rtl/devctl_data_port.sv
module devctl_data_port
    import ata_devctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ECC_W  = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xfer_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_ecc,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              drq,
    output logic [DATA_W-1:0] rdata,
    output logic              buf_pop,
    output logic              buf_push,
    output logic [DATA_W-1:0] buf_wr_data
);

    localparam logic [DATA_W-1:0] ECC_MASK = {{(DATA_W-ECC_W){1'b0}}, {ECC_W{1'b1}}};

    dp_state_t        state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             ecc_q;
    logic             access;
    logic             last;
    logic             open_blk;
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        access   = (acc_rd || acc_wr) && (state_q == DS_XFER);
        last     = (cnt_q == (len_q - LEN_W'(1)));
        open_blk = xfer_start && !dev_reset && (xfer_len != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
            ecc_q <= 1'b0;
        end else if (dev_reset) begin
            cnt_q <= '0;
        end else if ((state_q == DS_IDLE) && open_blk) begin
            cnt_q <= '0;
            len_q <= xfer_len;
            ecc_q <= xfer_ecc;
        end else if (access) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE: begin
                if (open_blk) state_d = DS_XFER;
            end
            DS_XFER: begin
                if (dev_reset) state_d = DS_IDLE;
                else if (access && last) state_d = DS_IDLE;
            end
        endcase
    end

    always_comb begin
        drq         = (state_q == DS_XFER);
        lane_mask   = ecc_q ? ECC_MASK : '1;
        rdata       = drq ? (buf_rd_data & lane_mask) : '0;
        buf_pop     = acc_rd && drq;
        buf_push    = acc_wr && drq;
        buf_wr_data = wdata & lane_mask;
    end

    AST_DRQ_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> ($past(dev_reset) ||
                        ($past(access) && ($past(cnt_q) == LEN_W'($past(len_q) - LEN_W'(1)))))); // R9

endmodule

// File: rtl/devctl_irq_gate.sv
module devctl_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_reset,
    input  logic irq_req,
    input  logic stat_rd,
    input  logic nien,
    input  logic selected,
    output logic host_intrq
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (dev_reset || stat_rd) begin
            pend_q <= 1'b0;
        end else if (irq_req) begin
            pend_q <= 1'b1;
        end
    end

    always_comb begin
        host_intrq = pend_q && !nien && selected;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !stat_rd && !dev_reset) |=> pend_q); // R6

endmodule

// File: rtl/ata_devctl_port.sv
module ata_devctl_port
    import ata_devctl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ECC_W    = 8,
    parameter int LEN_W    = 8,
    parameter int ADDR_W   = 4,
    parameter int MIN_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_strap,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_intrq,
    input  logic              irq_req,
    input  logic              xfer_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_ecc,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              buf_pop,
    output logic [DATA_W-1:0] buf_wr_data,
    output logic              buf_push,
    output logic              drq,
    output logic              dev_reset,
    output logic              hob
);

    logic              srst;
    logic              nien;
    logic              dev_sel;
    logic              selected;
    logic              data_sel;
    logic              stat_rd;
    logic [DATA_W-1:0] dp_rdata;

    always_comb begin
        data_sel = (host_addr == ADDR_W'(REG_DATA));
        stat_rd  = host_rd && (host_addr == ADDR_W'(REG_CMDSTAT));
        selected = (dev_sel == dev_strap);
    end

    devctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .addr      (host_addr),
        .wbit_hob  (host_wdata[CTL_HOB]),
        .wbit_srst (host_wdata[CTL_SRST]),
        .wbit_nien (host_wdata[CTL_NIEN]),
        .wbit_dev  (host_wdata[SEL_DEV]),
        .hob       (hob),
        .srst      (srst),
        .nien      (nien),
        .dev_sel   (dev_sel)
    );

    devctl_rst_seq #(.MIN_HOLD(MIN_HOLD)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .dev_reset (dev_reset)
    );

    devctl_data_port #(.DATA_W(DATA_W), .ECC_W(ECC_W), .LEN_W(LEN_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_reset   (dev_reset),
        .acc_rd      (host_rd && data_sel),
        .acc_wr      (host_wr && data_sel),
        .wdata       (host_wdata),
        .xfer_start  (xfer_start),
        .xfer_len    (xfer_len),
        .xfer_ecc    (xfer_ecc),
        .buf_rd_data (buf_rd_data),
        .drq         (drq),
        .rdata       (dp_rdata),
        .buf_pop     (buf_pop),
        .buf_push    (buf_push),
        .buf_wr_data (buf_wr_data)
    );

    devctl_irq_gate u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_reset  (dev_reset),
        .irq_req    (irq_req),
        .stat_rd    (stat_rd),
        .nien       (nien),
        .selected   (selected),
        .host_intrq (host_intrq)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (data_sel) begin
                host_rdata = dp_rdata;
            end else if (host_addr == ADDR_W'(REG_CMDSTAT)) begin
                host_rdata[STAT_BUSY] = dev_reset;
                host_rdata[STAT_DRQ]  = drq;
            end else if (host_addr == ADDR_W'(REG_DEVCTL)) begin
                host_rdata[CTL_HOB]  = hob;
                host_rdata[CTL_ONE]  = 1'b1;
                host_rdata[CTL_SRST] = srst;
                host_rdata[CTL_NIEN] = nien;
            end
        end
    end

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_reset) |=> (!drq && !host_intrq)); // R3

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        host_intrq |-> (!nien && (dev_sel == dev_strap))); // R5

    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && data_sel && !drq) |-> (!buf_pop && (host_rdata == '0))); // R8

endmodule

// File: tb/ata_devctl_port_tb.sv
module ata_devctl_port_tb;

    localparam int MIN_HOLD = 16;
    localparam int NVEC     = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_strap = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_intrq;
    logic        irq_req = 1'b0;
    logic        xfer_start = 1'b0;
    logic [7:0]  xfer_len = '0;
    logic        xfer_ecc = 1'b0;
    logic [15:0] buf_rd_data = '0;
    logic        buf_pop;
    logic [15:0] buf_wr_data;
    logic        buf_push;
    logic        drq;
    logic        dev_reset;
    logic        hob;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ata_devctl_port #(.MIN_HOLD(MIN_HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_strap(dev_strap),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_intrq(host_intrq),
        .irq_req(irq_req), .xfer_start(xfer_start), .xfer_len(xfer_len),
        .xfer_ecc(xfer_ecc), .buf_rd_data(buf_rd_data), .buf_pop(buf_pop),
        .buf_wr_data(buf_wr_data), .buf_push(buf_push), .drq(drq),
        .dev_reset(dev_reset), .hob(hob)
    );

    // vector: {op[1:0] (1 write, 2 read), addr[3:0], wdata[15:0], expected read[15:0]}
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd2, 4'd8, 16'h0000, 16'h0008},  // R1 reset image
        {2'd1, 4'd8, 16'h0082, 16'h0000},  // R1 set select + mask
        {2'd2, 4'd8, 16'h0000, 16'h008A},  // R1
        {2'd1, 4'd2, 16'h1234, 16'h0000},  // R2 command-block write
        {2'd2, 4'd8, 16'h0000, 16'h000A},  // R2
        {2'd1, 4'd8, 16'h0080, 16'h0000},
        {2'd2, 4'd8, 16'h0000, 16'h0088},  // R1
        {2'd1, 4'd0, 16'hBEEF, 16'h0000},  // R2/R8 data write, no DRQ
        {2'd2, 4'd8, 16'h0000, 16'h0008},  // R2
        {2'd2, 4'd7, 16'h0000, 16'h0000},  // R10 idle status
        {2'd2, 4'd0, 16'h0000, 16'h0000},  // R8 data read, no DRQ
        {2'd1, 4'd8, 16'h0000, 16'h0000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic is_wr, input logic [3:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output logic pop, output logic push,
                           output logic [15:0] wd);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = is_wr;
        host_rd    = !is_wr;
        #1;
        rd   = host_rdata;
        pop  = buf_pop;
        push = buf_push;
        wd   = buf_wr_data;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_req = 1'b1;
        @(posedge clk);
        #1;
        irq_req = 1'b0;
    endtask

    task automatic start_blk(input logic [7:0] len, input logic ecc);
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_len   = len;
        xfer_ecc   = ecc;
        @(posedge clk);
        #1;
        xfer_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, wd;
        logic pop, push;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        check("R3 reset dev_reset", {15'd0, dev_reset}, 16'd0);
        check("R9 reset drq", {15'd0, drq}, 16'd0);
        check("R5 reset intrq", {15'd0, host_intrq}, 16'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            host_op(VEC[i][37:36] == 2'd1, VEC[i][35:32], VEC[i][31:16], rd, pop, push, wd);
            if (VEC[i][37:36] == 2'd2) check($sformatf("R1/R2/R8/R10 vec %0d read", i), rd, VEC[i][15:0]);
            check($sformatf("R8 vec %0d no buffer strobe", i), {14'd0, pop, push}, 16'd0);
        end

        // interrupt gating
        pulse_irq();
        check("R6 pending shows", {15'd0, host_intrq}, 16'd1);
        host_op(1'b1, 4'd8, 16'h0002, rd, pop, push, wd);
        check("R5 masked", {15'd0, host_intrq}, 16'd0);
        host_op(1'b1, 4'd8, 16'h0000, rd, pop, push, wd);
        check("R6 held while masked", {15'd0, host_intrq}, 16'd1);
        host_op(1'b1, 4'd6, 16'h0010, rd, pop, push, wd);
        check("R5 deselected", {15'd0, host_intrq}, 16'd0);
        dev_strap = 1'b1;
        #1;
        check("R5 strap 1 matches", {15'd0, host_intrq}, 16'd1);
        dev_strap = 1'b0;
        host_op(1'b1, 4'd6, 16'h0000, rd, pop, push, wd);
        check("R5 reselected", {15'd0, host_intrq}, 16'd1);
        host_op(1'b0, 4'd7, 16'h0000, rd, pop, push, wd);
        check("R6 status read clears", {15'd0, host_intrq}, 16'd0);

        // 16-bit block
        buf_rd_data = 16'hA5C3;
        start_blk(8'd3, 1'b0);
        check("R9 drq rises", {15'd0, drq}, 16'd1);
        host_op(1'b0, 4'd0, 16'h0000, rd, pop, push, wd);
        check("R7 word read", rd, 16'hA5C3);
        check("R7 pop", {15'd0, pop}, 16'd1);
        host_op(1'b1, 4'd0, 16'hBEEF, rd, pop, push, wd);
        check("R7 word write", wd, 16'hBEEF);
        check("R7 push", {15'd0, push}, 16'd1);
        host_op(1'b0, 4'd7, 16'h0000, rd, pop, push, wd);
        check("R10 status drq", rd, 16'h0008);
        check("R9 drq held mid block", {15'd0, drq}, 16'd1);
        host_op(1'b0, 4'd0, 16'h0000, rd, pop, push, wd);
        check("R9 drq falls after len", {15'd0, drq}, 16'd0);

        // check-byte block
        buf_rd_data = 16'hABCD;
        start_blk(8'd2, 1'b1);
        host_op(1'b0, 4'd0, 16'h0000, rd, pop, push, wd);
        check("R7 ecc read low byte", rd, 16'h00CD);
        host_op(1'b1, 4'd0, 16'h1234, rd, pop, push, wd);
        check("R7 ecc write low byte", wd, 16'h0034);
        check("R9 ecc block done", {15'd0, drq}, 16'd0);

        // software reset, early release
        start_blk(8'd4, 1'b0);
        pulse_irq();
        host_op(1'b1, 4'd8, 16'h0004, rd, pop, push, wd);
        check("R3 dev_reset rises", {15'd0, dev_reset}, 16'd1);
        @(posedge clk);
        #1;
        check("R3 drq flushed", {15'd0, drq}, 16'd0);
        check("R3 irq flushed", {15'd0, host_intrq}, 16'd0);
        host_op(1'b0, 4'd7, 16'h0000, rd, pop, push, wd);
        check("R10 status busy", rd, 16'h0080);
        start_blk(8'd2, 1'b0);
        check("R9 start ignored in reset", {15'd0, drq}, 16'd0);
        host_op(1'b1, 4'd8, 16'h0000, rd, pop, push, wd);
        repeat (4) @(posedge clk);
        #1;
        check("R4 early release extended", {15'd0, dev_reset}, 16'd1);
        repeat (MIN_HOLD + 4) @(posedge clk);
        #1;
        check("R4 extended release done", {15'd0, dev_reset}, 16'd0);

        // software reset, full hold
        host_op(1'b1, 4'd8, 16'h0004, rd, pop, push, wd);
        repeat (MIN_HOLD + 4) @(posedge clk);
        #1;
        check("R4 held while bit set", {15'd0, dev_reset}, 16'd1);
        host_op(1'b1, 4'd8, 16'h0000, rd, pop, push, wd);
        @(posedge clk);
        #1;
        check("R4 release after hold", {15'd0, dev_reset}, 16'd0);
        pulse_irq();
        check("R6 irq after reset", {15'd0, host_intrq}, 16'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule